// File: doc/BRIEF.md
# Nine-bit command/data serial transmitter

This block sends single bytes to a display controller over a write-only serial link with three wires: an active-low select, a serial clock and a data line. The block adds a flag bit to each byte that tells the receiver whether the byte is a command or a parameter. This removes the need for a separate data/command pin. Every transfer on the wire is therefore one nine-bit word. The flag travels first, followed by the payload with its most significant bit first.

Upstream logic offers a byte and its flag on a valid/ready handshake. The block takes one word only while it is idle. It then lowers select, shifts the nine bits out at a rate set by a clock-divider parameter, and releases select. Only after that does it accept the next word. The serial clock idles low. The data line changes only while the clock is low, so the receiver can sample on the rising edge.

Top module: `n9tx_top`

## Requirements
- R1: Every select window contains exactly 9 rising edges of `sclk`. Select stays low for 9*CLK_DIV + CLK_DIV/2 system clock cycles.
- R2: The word is sent most significant bit first. Bit 8 of the word is the kind flag, and bits 7..0 are the payload byte, sent from bit 7 down to bit 0.
- R3: A kind flag of 0 (command byte) makes the first bit of the word 0 on `sdo` at the first rising edge.
- R4: A kind flag of 1 (parameter/data byte) makes the first bit of the word 1 on `sdo` at the first rising edge.
- R5: `sclk` is low whenever select is released. `sdo` holds its value for every cycle that `sclk` is high, so it changes only while `sclk` is low.
- R6: `in_ready` is high exactly when the block is idle. It drops in the cycle after a word is accepted, stays low while select is low, and returns high in the cycle select is released. `busy` is its inverse.
- R7: Each high phase of `sclk` lasts CLK_DIV - CLK_DIV/2 cycles. Each low phase inside a select window, including the one before the first edge and the one after the last edge, lasts CLK_DIV/2 cycles.
- R8: While busy, the block ignores `in_valid`, `in_kind` and `in_byte`. The word on the wire is the one accepted at the start of the window.
- R9: After reset, `cs_n` is 1, `sclk` is 0, `sdo` is 0, `in_ready` is 1 and `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A word is offered |
| in_ready | output | 1 | Block is idle and takes the offered word |
| in_kind | input | 1 | 0 = command byte, 1 = parameter/data byte |
| in_byte | input | PAYLOAD_W | Payload byte |
| cs_n | output | 1 | Select to the receiver, active low |
| sclk | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data, valid on the rising edge of sclk |
| busy | output | 1 | A word is in flight |

## Verification
The assertions check on every cycle that the clock is low outside a window and that data is frozen while the clock is high. They also check that ready is low for the whole select window and returns when select is released, and that each window holds exactly nine rising edges. Some behaviour can only be shown by the bench's scenarios, which sweep every payload byte with both flag values and watch the wire. These are the exact bit order, the flag polarity, the low-phase and high-phase lengths, and the fact that input changes during a window do not reach the wire.

// File: rtl/n9tx_pkg.sv
// Package: shared types of the nine-bit serial transmitter.
// Assumes: nothing beyond IEEE 1800-2017.
package n9tx_pkg;

    // Sequencer states: idle, clock low phase, clock high phase, tail before release
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_TAIL = 2'd3
    } seq_state_t;

    // Build the wire word: kind flag above the payload
    function automatic logic [8:0] pack_word8(input logic kind, input logic [7:0] payload);
        return {kind, payload};
    endfunction

endpackage

// File: rtl/n9tx_phase_timer.sv
// Module: counts the length of the current serial clock phase.
// Does: raises done on the last cycle of a low phase (LO cycles) or of a
//       high phase (HI cycles), chosen by phase_high.
// Assumes: LO >= 1, HI >= LO; clear holds the count at zero.
module n9tx_phase_timer #(
    parameter int LO = 2,
    parameter int HI = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic phase_high,
    output logic done
);
    localparam int CW = $clog2(HI + 1);
    localparam logic [CW-1:0] LO_LAST = CW'(LO - 1);
    localparam logic [CW-1:0] HI_LAST = CW'(HI - 1);

    logic [CW-1:0] cnt;

    // Terminal count of the phase in progress
    always_comb begin
        done = (cnt == (phase_high ? HI_LAST : LO_LAST));
    end

    // Phase cycle counter, restarts at each phase boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear || done) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/n9tx_word_shifter.sv
// Module: holds the word being sent and tracks which bit is on the wire.
// Does: load captures a new word; shift moves the next bit to the top.
// Assumes: load and shift are never high together.
module n9tx_word_shifter #(
    parameter int WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              shift,
    output logic              msb,
    output logic              last
);
    localparam int IW = $clog2(WORD_W);
    localparam logic [IW-1:0] IDX_LAST = IW'(WORD_W - 1);

    logic [WORD_W-1:0] shreg;
    logic [IW-1:0]     idx;

    // Bit on the wire and end-of-word flag
    always_comb begin
        msb  = shreg[WORD_W-1];
        last = (idx == IDX_LAST);
    end

    // Shift register and bit index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            idx   <= '0;
        end else if (load) begin
            shreg <= load_word;
            idx   <= '0;
        end else if (shift) begin
            shreg <= {shreg[WORD_W-2:0], 1'b0};
            idx   <= idx + 1'b1;
        end
    end

endmodule

// File: rtl/n9tx_seq_fsm.sv
// Module: sequencer for one select window.
// Does: idle -> (low, high) x WORD_W -> tail -> idle; accepts only when idle.
// Assumes: timer_done marks the last cycle of the current phase.
module n9tx_seq_fsm
    import n9tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       timer_done,
    input  logic       last_bit,
    output seq_state_t state,
    output logic       accept,
    output logic       shift,
    output logic       timer_clear,
    output logic       phase_high
);
    seq_state_t state_nx;

    // Handshake and datapath strobes decoded from the state
    always_comb begin
        accept      = (state == ST_IDLE) && in_valid;
        shift       = (state == ST_HIGH) && timer_done && !last_bit;
        timer_clear = (state == ST_IDLE);
        phase_high  = (state == ST_HIGH);
    end

    // Next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept)     state_nx = ST_LOW;
            ST_LOW:  if (timer_done) state_nx = ST_HIGH;
            ST_HIGH: if (timer_done) state_nx = last_bit ? ST_TAIL : ST_LOW;
            ST_TAIL: if (timer_done) state_nx = ST_IDLE;
            default:                 state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

endmodule

// File: rtl/n9tx_top.sv
// Module: nine-bit command/data serial transmitter, top level.
// Does: takes one payload plus kind flag on valid/ready and sends it as
//       {kind, payload} MSB first inside one active-low select window; the
//       serial clock idles low and data moves only while it is low.
// Assumes: CLK_DIV >= 2; the receiver samples on the rising sclk edge.
module n9tx_top
    import n9tx_pkg::*;
#(
    parameter int PAYLOAD_W = 8,
    parameter int CLK_DIV   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic                 in_kind,
    input  logic [PAYLOAD_W-1:0] in_byte,
    output logic                 cs_n,
    output logic                 sclk,
    output logic                 sdo,
    output logic                 busy
);
    localparam int WORD_W = PAYLOAD_W + 1;
    localparam int LO     = CLK_DIV / 2;
    localparam int HI     = CLK_DIV - LO;

    generate
        if (CLK_DIV < 2) begin : g_bad_div
            $error("n9tx_top: CLK_DIV must be at least 2");
        end
    endgenerate

    seq_state_t state;
    logic accept, shift, timer_clear, phase_high, timer_done;
    logic bit_msb, bit_last;

    n9tx_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .timer_done  (timer_done),
        .last_bit    (bit_last),
        .state       (state),
        .accept      (accept),
        .shift       (shift),
        .timer_clear (timer_clear),
        .phase_high  (phase_high)
    );

    n9tx_phase_timer #(.LO(LO), .HI(HI)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (timer_clear),
        .phase_high (phase_high),
        .done       (timer_done)
    );

    n9tx_word_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_word ({in_kind, in_byte}),
        .shift     (shift),
        .msb       (bit_msb),
        .last      (bit_last)
    );

    // Pin decode from the registered state and shift register
    always_comb begin
        in_ready = (state == ST_IDLE);
        busy     = (state != ST_IDLE);
        cs_n     = (state == ST_IDLE);
        sclk     = (state == ST_HIGH);
        sdo      = (state != ST_IDLE) && bit_msb;
    end

endmodule

// File: rtl/n9tx_checker.sv
// Module: protocol checker for n9tx_top, attached by bind.
// Does: checks clock idle level, data stability, ready/select coupling and
//       the rising-edge count of each window.
// Assumes: WORD_W matches the transmitter's word length.
module n9tx_checker #(
    parameter int WORD_W = 9
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic cs_n,
    input logic sclk,
    input logic sdo
);
    logic       sclk_q;
    logic [7:0] rise_cnt;

    // Count sclk rising edges inside the current window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q   <= 1'b0;
            rise_cnt <= '0;
        end else begin
            sclk_q   <= sclk;
            rise_cnt <= cs_n ? 8'd0 : rise_cnt + {7'd0, sclk && !sclk_q};
        end
    end

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);                                           // R5
    AST_SDO_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdo));                   // R5
    AST_NOT_READY_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> !in_ready);                                      // R6
    AST_ACCEPT_OPENS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (!cs_n && !in_ready));          // R6
    AST_READY_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> in_ready);                                 // R6
    AST_NINE_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (rise_cnt == 8'(WORD_W)));                 // R1

endmodule

bind n9tx_top n9tx_checker #(.WORD_W(WORD_W)) u_n9tx_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .sdo      (sdo)
);

// File: tb/tb_n9tx_top.sv
// Bench: sweeps every payload byte with both kind flags and decodes the wire.
module tb_n9tx_top;
    localparam int DIV    = 4;
    localparam int LO     = DIV / 2;
    localparam int HI     = DIV - LO;
    localparam int NWORDS = 512;
    localparam int CS_LEN = 9 * DIV + LO;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_kind = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_ready, cs_n, sclk, sdo, busy;

    int nchk = 0;
    int nerr = 0;

    logic [8:0] exp_word [NWORDS];
    int wr_idx = 0;
    int rd_idx = 0;

    always #10 clk = ~clk;

    n9tx_top #(.PAYLOAD_W(8), .CLK_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_kind(in_kind), .in_byte(in_byte), .cs_n(cs_n), .sclk(sclk),
        .sdo(sdo), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    // Wire monitor, sampled on the falling system clock edge
    logic       prev_cs = 1'b1, prev_sclk = 1'b0, prev_sdo = 1'b0;
    int         cyc, rises, run;
    logic [8:0] got;
    bit         bad_phase, bad_ready, bad_stable;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!cs_n) begin
                if (prev_cs) begin
                    cyc = 0; rises = 0; run = 0; got = '0;
                    bad_phase = 0; bad_ready = 0; bad_stable = 0;
                end
                cyc++;
                if (in_ready || !busy) bad_ready = 1;
                if (sclk && !prev_sclk) begin
                    rises++;
                    got = {got[7:0], sdo};
                    if (run != LO) bad_phase = 1;
                    run = 0;
                end else if (!sclk && prev_sclk) begin
                    if (run != HI) bad_phase = 1;
                    run = 0;
                end
                if (sclk && prev_sclk && sdo != prev_sdo) bad_stable = 1;
                run++;
            end else if (!prev_cs) begin
                logic [8:0] e;
                e = exp_word[rd_idx];
                rd_idx++;
                chk(rises == 9, "R1 rising edges per window", rises, 9);
                chk(cyc == CS_LEN, "R1 select window length", cyc, CS_LEN);
                chk(got[7:0] == e[7:0], "R2 payload bits MSB first", got[7:0], e[7:0]);
                chk(got == e, "R8 word equals accepted word", got, e);
                if (e[8] == 1'b0)
                    chk(got[8] == 1'b0, "R3 command flag first bit", got[8], 0);
                else
                    chk(got[8] == 1'b1, "R4 data flag first bit", got[8], 1);
                chk(!bad_stable, "R5 sdo stable while sclk high", bad_stable, 0);
                chk(!bad_phase && run == LO, "R7 phase lengths", run, LO);
                chk(!bad_ready, "R6 ready low during window", bad_ready, 0);
                chk(in_ready && !busy && !sclk, "R6 ready back on release", in_ready, 1);
            end
            if (cs_n && sclk) chk(1'b0, "R5 sclk low while released", sclk, 0);
        end
        prev_cs   = cs_n;
        prev_sclk = sclk;
        prev_sdo  = sdo;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL watchdog expired frames=%0d expected=%0d", rd_idx, NWORDS);
        finish_run();
    end

    // Stimulus
    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b0 && sdo == 1'b0, "R9 pins in reset", {cs_n, sclk, sdo}, 4);
        chk(in_ready == 1'b1 && busy == 1'b0, "R9 ready in reset", in_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == 1'b1 && in_ready == 1'b1, "R9 idle after reset", in_ready, 1);
        for (int i = 0; i < NWORDS; i++) begin
            logic       k;
            logic [7:0] b;
            k = i[0];
            b = 8'(i >> 1) ^ (k ? 8'h00 : 8'hA5);
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1; in_kind = k; in_byte = b;
            exp_word[wr_idx] = {k, b};
            wr_idx++;
            @(negedge clk);
            chk(!in_ready && busy && !cs_n, "R6 accept drops ready", in_ready, 0);
            if (i % 2 == 0) begin
                // R8: inputs change while busy, must not reach the wire
                in_kind = ~k; in_byte = ~b;
                repeat (10) @(negedge clk);
            end
            in_valid = 1'b0;
        end
        while (rd_idx < NWORDS) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(rd_idx == NWORDS && cs_n, "R1 all windows seen", rd_idx, NWORDS);
        finish_run();
    end

endmodule